// File: doc/BRIEF.md
# General-Purpose Port Register with Power-Mode Request Bits

This block holds the direction settings and output values of one 8-bit general-purpose I/O port. It also returns the level of each pin through a pin-read location. The six low bit positions are ordinary bidirectional I/O. In each of them, a direction bit enables the output driver and a value bit sets the driven level.

The two upper positions are not normal I/O. Pin 6 is input-only, and pin 7 carries a clock that is generated elsewhere. Their slots in the value register are therefore reused as write-triggered requests. A write with bit 7 set sends a one-cycle stop (HALT) request to the power controller. A write with bit 6 set sends a one-cycle low-power wait (IDLE) request. Neither request is stored, so both bits always read back as zero. If a single write sets both bits, the stop request wins.

Direction-register bit 6 selects the alternate phase of the serial shift clock. Direction-register bit 7 has no function.

Software reaches the block through a small register bus with a 2-bit location select, a write strobe, write data and combinational read data. Location 0 is the direction register, location 1 is the value register, location 2 is the pin read and location 3 is unused.

Top module: `gport_ctl`

## Requirements
- R1: After reset, the direction and value registers read 0, every `pin_oe` bit is 0, `pin_out` is 0, and `halt_req`, `idle_req` and `sk_alt` are low.
- R2: A write to location 0 (`sel`=2'd0) stores bits 6..0. Reading location 0 returns those seven bits, and bit 7 always reads 0.
- R3: A write to location 1 (`sel`=2'd1) stores bits 5..0. Reading location 1 returns those bits, and bits 7 and 6 always read 0.
- R4: For each bit i from 0 to 5, `pin_oe[i]` equals direction bit i and `pin_out[i]` equals value bit i. `pin_oe[7:6]` and `pin_out[7:6]` are always 0.
- R5: A location-1 write whose data bit 7 is 1 raises `halt_req` for exactly the one cycle that follows the write edge.
- R6: A location-1 write whose data bit 6 is 1 and bit 7 is 0 raises `idle_req` for exactly the one cycle that follows the write edge.
- R7: A location-1 write with both bit 7 and bit 6 set raises only `halt_req`. `idle_req` stays low.
- R8: `sk_alt` equals direction-register bit 6. It changes on the edge of a location-0 write.
- R9: Reading location 2 (`sel`=2'd2) returns `pin_in[6:0]` in bits 6..0, and bit 7 reads 0.
- R10: Writes to location 2 or 3 change no register and raise no request. Reading location 3 returns 0.
- R11: While `wr_en` is low, no register changes and no request is raised, whatever `sel` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 2 | Location select: 0 direction, 1 value, 2 pin read, 3 unused |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for the selected location |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Levels driven on the pins |
| pin_oe | output | 8 | Output enables for the pins |
| halt_req | output | 1 | One-cycle stop-mode request |
| idle_req | output | 1 | One-cycle wait-mode request |
| sk_alt | output | 1 | Alternate serial clock phase select |

## Verification
A wrong stored direction or value bit appears at `pin_oe`, `pin_out` or `sk_alt` in the cycle right after the write edge. The same fault appears on a readback of location 0 or 1 with no further delay. A mode request that is stored by mistake stays high for a second cycle, or returns a 1 in the upper value bits. A missed priority shows as both request lines high together. Each of these faults is visible within two cycles of the write that exposes it. The bench therefore checks every request line in the cycle after the write edge and again one cycle later.

// File: rtl/gport_pkg.sv
package gport_pkg;

  localparam int unsigned PORT_W = 8;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    LOC_DIR  = 2'd0,
    LOC_VAL  = 2'd1,
    LOC_PIN  = 2'd2,
    LOC_NONE = 2'd3
  } loc_e;

  // bits of the direction register that hold state: all but the top one
  function automatic logic [PORT_W-1:0] dir_keep_mask();
    logic [PORT_W-1:0] m;
    m = '1;
    m[PORT_W-1] = 1'b0;
    return m;
  endfunction

  // bits of the value register that hold state: all but the two request slots
  function automatic logic [PORT_W-1:0] val_keep_mask();
    logic [PORT_W-1:0] m;
    m = '1;
    m[PORT_W-1] = 1'b0;
    m[PORT_W-2] = 1'b0;
    return m;
  endfunction

  // pin read: the top pin is a dedicated clock output and reads as zero
  function automatic logic [PORT_W-1:0] pin_read_mask();
    logic [PORT_W-1:0] m;
    m = '1;
    m[PORT_W-1] = 1'b0;
    return m;
  endfunction

  function automatic logic halt_hit(input logic [PORT_W-1:0] wd);
    return wd[PORT_W-1];
  endfunction

  function automatic logic idle_hit(input logic [PORT_W-1:0] wd);
    return wd[PORT_W-2] & ~wd[PORT_W-1];
  endfunction

endpackage

// File: rtl/gport_store.sv
module gport_store #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q[i] <= 1'b0;
        else if (we) q[i] <= wd[i];
      end
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gport_mode_req.sv
module gport_mode_req
  import gport_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic         halt_q,
  output logic         idle_q
);

  logic halt_d, idle_d;

  always_comb begin
    halt_d = we & halt_hit(wd);
    idle_d = we & idle_hit(wd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
      idle_q <= idle_d;
    end
  end

endmodule

// File: rtl/gport_pin_drive.sv
module gport_pin_drive #(
  parameter int unsigned W    = 8,
  parameter int unsigned N_IO = W - 2
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] val_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i < N_IO) begin : g_io
      assign pin_oe[i]  = dir_q[i];
      assign pin_out[i] = val_q[i];
    end else begin : g_special
      assign pin_oe[i]  = 1'b0;
      assign pin_out[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gport_read_mux.sv
module gport_read_mux
  import gport_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  loc_e         loc,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] val_q,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rd_data
);

  always_comb begin
    unique case (loc)
      LOC_DIR: rd_data = dir_q & dir_keep_mask();
      LOC_VAL: rd_data = val_q & val_keep_mask();
      LOC_PIN: rd_data = pin_in & pin_read_mask();
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/gport_ctl.sv
module gport_ctl
  import gport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              halt_req,
  output logic              idle_req,
  output logic              sk_alt
);

  localparam int unsigned N_IO   = PORT_W - 2;
  localparam int unsigned SK_BIT = PORT_W - 2;

  loc_e              loc;
  logic              wr_dir_ev;
  logic              wr_val_ev;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] val_q;

  assign loc       = loc_e'(sel);
  assign wr_dir_ev = wr_en & (loc == LOC_DIR);
  assign wr_val_ev = wr_en & (loc == LOC_VAL);

  gport_store #(.W(PORT_W), .KEEP(dir_keep_mask())) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wr_dir_ev), .wd(wr_data), .q(dir_q)
  );

  gport_store #(.W(PORT_W), .KEEP(val_keep_mask())) u_val (
    .clk(clk), .rst_n(rst_n), .we(wr_val_ev), .wd(wr_data), .q(val_q)
  );

  gport_mode_req #(.W(PORT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .we(wr_val_ev), .wd(wr_data),
    .halt_q(halt_req), .idle_q(idle_req)
  );

  gport_pin_drive #(.W(PORT_W), .N_IO(N_IO)) u_drv (
    .dir_q(dir_q), .val_q(val_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gport_read_mux #(.W(PORT_W)) u_rd (
    .loc(loc), .dir_q(dir_q), .val_q(val_q), .pin_in(pin_in), .rd_data(rd_data)
  );

  assign sk_alt = dir_q[SK_BIT];

endmodule

// File: rtl/gport_ctl_chk.sv
module gport_ctl_chk
  import gport_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel,
  input logic              wr_en,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] rd_data,
  input logic [PORT_W-1:0] pin_out,
  input logic [PORT_W-1:0] pin_oe,
  input logic              halt_req,
  input logic              idle_req,
  input logic              sk_alt
);

  p_halt_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_en && sel == 2'd1 && wr_data[7]));

  p_idle_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_req |-> $past(wr_en && sel == 2'd1 && wr_data[6] && !wr_data[7]));

  p_halt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd1 && wr_data[7]) |=> !idle_req);

  p_val_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd1) |-> (rd_data[7:6] == 2'b00));

  p_oe_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0) |=> (pin_oe[5:0] == $past(wr_data[5:0])));

  p_sk_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0) |=> (sk_alt == $past(wr_data[6])));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (sel == 2'd0 || sel == 2'd1)) |=>
      ($stable(pin_oe) && $stable(pin_out) && $stable(sk_alt) && !halt_req && !idle_req));

endmodule

bind gport_ctl gport_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe),
  .halt_req(halt_req), .idle_req(idle_req), .sk_alt(sk_alt)
);

// File: tb/gport_ctl_tb.sv
module gport_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] pin_in = 8'h00;
  logic [7:0] pin_out, pin_oe;
  logic       halt_req, idle_req, sk_alt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gport_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .halt_req(halt_req), .idle_req(idle_req), .sk_alt(sk_alt)
  );

  task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", what, got, exp);
    end
  endtask

  // write at one edge; returns at the following falling edge (pulse window)
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    sel = a;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk("R1 dir after reset", v, 8'h00);
    rd(2'd1, v); chk("R1 val after reset", v, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 req/sk", {5'd0, halt_req, idle_req, sk_alt}, 8'h00);
  endtask

  task automatic t_dir_rw();
    logic [7:0] v;
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R2 dir FF readback", v, 8'h7F);
    wr(2'd0, 8'h25);
    rd(2'd0, v); chk("R2 dir 25 readback", v, 8'h25);
  endtask

  task automatic t_val_rw();
    logic [7:0] v;
    wr(2'd1, 8'h3A);
    rd(2'd1, v); chk("R3 val 3A readback", v, 8'h3A);
    @(negedge clk);
    wr(2'd1, 8'h15);
    rd(2'd1, v); chk("R3 val 15 readback", v, 8'h15);
  endtask

  task automatic t_drive();
    wr(2'd0, 8'hEA);
    wr(2'd1, 8'h27);
    chk("R4 pin_oe", pin_oe, 8'h2A);
    chk("R4 pin_out", pin_out, 8'h27);
    wr(2'd0, 8'h3F);
    chk("R4 pin_oe all io", pin_oe, 8'h3F);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    wr(2'd1, 8'h81);
    chk("R5 halt pulse high", {6'd0, halt_req, idle_req}, 8'h02);
    rd(2'd1, v); chk("R5 halt bit reads 0", v, 8'h01);
    @(negedge clk);
    chk("R5 halt pulse one cycle", {6'd0, halt_req, idle_req}, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    wr(2'd1, 8'h42);
    chk("R6 idle pulse high", {6'd0, halt_req, idle_req}, 8'h01);
    rd(2'd1, v); chk("R6 idle bit reads 0", v, 8'h02);
    @(negedge clk);
    chk("R6 idle pulse one cycle", {6'd0, halt_req, idle_req}, 8'h00);
  endtask

  task automatic t_both();
    wr(2'd1, 8'hC0);
    chk("R7 halt only", {6'd0, halt_req, idle_req}, 8'h02);
    @(negedge clk);
    chk("R7 after", {6'd0, halt_req, idle_req}, 8'h00);
  endtask

  task automatic t_sk();
    wr(2'd0, 8'h40);
    chk("R8 sk_alt set", {7'd0, sk_alt}, 8'h01);
    chk("R8 pin_oe unaffected", pin_oe, 8'h00);
    wr(2'd0, 8'h80);
    chk("R8 sk_alt clear", {7'd0, sk_alt}, 8'h00);
  endtask

  task automatic t_pin_read();
    logic [7:0] v;
    pin_in = 8'hC5;
    rd(2'd2, v); chk("R9 pin read C5", v, 8'h45);
    pin_in = 8'h7A;
    rd(2'd2, v); chk("R9 pin read 7A", v, 8'h7A);
  endtask

  task automatic t_unused();
    logic [7:0] v;
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h22);
    wr(2'd2, 8'hFF);
    chk("R10 no req from pin write", {6'd0, halt_req, idle_req}, 8'h00);
    wr(2'd3, 8'hC0);
    chk("R10 no req from loc3 write", {6'd0, halt_req, idle_req}, 8'h00);
    rd(2'd3, v); chk("R10 loc3 reads 0", v, 8'h00);
    rd(2'd0, v); chk("R10 dir kept", v, 8'h11);
    rd(2'd1, v); chk("R10 val kept", v, 8'h22);
  endtask

  task automatic t_no_wren();
    logic [7:0] v;
    @(negedge clk);
    sel = 2'd1; wr_data = 8'hFF; wr_en = 1'b0;
    @(negedge clk);
    chk("R11 no req without strobe", {6'd0, halt_req, idle_req}, 8'h00);
    sel = 2'd0;
    @(negedge clk);
    rd(2'd0, v); chk("R11 dir unchanged", v, 8'h11);
    rd(2'd1, v); chk("R11 val unchanged", v, 8'h22);
    chk("R11 pin_out unchanged", pin_out, 8'h22);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_rw();
    t_val_rw();
    t_drive();
    t_halt();
    t_idle();
    t_both();
    t_sk();
    t_pin_read();
    t_unused();
    t_no_wren();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule